// File: doc/BRIEF.md
# Three-Mode Serial Port with Ninth-Bit Framing

This block is a serial port that can work in three ways. In the synchronous shift mode, it moves eight bits, least significant bit first, over a single bidirectional data pin while the `txd` pin supplies the shift clock. In the 10-bit asynchronous mode, a frame is a start bit, eight data bits and a stop bit. In the 11-bit asynchronous mode, a ninth data bit comes before the stop bit. The host places a byte and a ninth bit on the transmit inputs and pulses `tx_start`. Received bytes appear on `rx_data`, together with a ninth-bit/stop-bit field and a framing-error flag.

All timing comes from one oversample tick, and every bit lasts 16 ticks:

- **Shift mode:** the tick fires on every clock.
- **11-bit mode:** the tick fires on every clock or on every second clock, chosen by `slow_rate`.
- **10-bit mode:** the tick is taken from one of two external pulse inputs. One is a timer overflow and the other is an independent rate generator.

The asynchronous receiver detects the falling edge of a start bit. It takes three samples around the middle of each bit and keeps their majority value. It drops a start bit that is not low at mid-bit.

Each direction has a done flag. A flag is set at the end of its frame and stays set until software writes 0 to it.

Transmitter states:

- `TX_IDLE`: waits for `tx_start`.
  - `TX_IDLE -> TX_DATA` in shift mode.
  - `TX_IDLE -> TX_START` in the asynchronous modes.
- `TX_START`: sends the start bit, then moves `TX_START -> TX_DATA`.
- `TX_DATA`: sends eight data bits, then moves to one of:
  - `TX_IDLE` in shift mode,
  - `TX_NINTH` in the 11-bit mode,
  - `TX_STOP` in the 10-bit mode.
- `TX_NINTH`: sends the ninth bit, then moves `TX_NINTH -> TX_STOP`.
- `TX_STOP`: sends the stop bit, then moves `TX_STOP -> TX_IDLE` and sets the transmit done flag.

Receiver states:

- `RX_IDLE`: waits for a frame to begin.
  - `RX_IDLE -> RX_DATA` on `rx_start` in shift mode.
  - `RX_IDLE -> RX_START` when the line is seen low in an asynchronous mode.
- `RX_START`: checks the start bit at mid-bit.
  - `RX_START -> RX_IDLE` on a false start.
  - `RX_START -> RX_DATA` on a valid start.
- `RX_DATA`: takes in eight data bits, then moves to one of:
  - `RX_IDLE` in shift mode,
  - `RX_NINTH` in the 11-bit mode,
  - `RX_STOP` in the 10-bit mode.
- `RX_NINTH`: takes the ninth bit, then moves `RX_NINTH -> RX_STOP`.
- `RX_STOP`: moves `RX_STOP -> RX_IDLE` at the middle of the stop bit.

Top module: `mser_core`

## Requirements
- R1: Shift-mode transmit (mode 0).
  - While the frame runs, `rxd_oe` is 1 and `rxd_out` carries the byte, least significant bit first, with each bit lasting 16 clocks.
  - Within each bit, `txd` is 0 for the first 8 clocks and 1 for the last 8 clocks.
  - When the port is idle, `txd` is 1 and `rxd_oe` is 0.
- R2: Shift-mode receive (mode 0).
  - A pulse on `rx_start` produces 8 shift-clock periods on `txd`, with the same low/high pattern as R1.
  - The port samples `rxd_in` in the middle of each period, least significant bit first, and places the byte on `rx_data`.
  - `rx_bit8` and `frame_err` keep their previous values.
- R3: 10-bit asynchronous transmit (mode 1).
  - `txd` sends a 0 start bit, then `tx_data` least significant bit first, then a 1 stop bit.
  - Each bit lasts 16 ticks. The tick is `tmr_ovf_tick` when `baud_sel` is 0 and `gen_tick` when `baud_sel` is 1.
- R4: 11-bit asynchronous transmit (mode 2).
  - `txd` sends the start bit, the eight data bits, then `tx_bit9`, then a 1 stop bit.
  - Each bit lasts 16 clocks when `slow_rate` is 0 and 32 clocks when it is 1.
- R5: 10-bit asynchronous receive (mode 1).
  - The received stop bit goes to `rx_bit8` and the byte goes to `rx_data`.
  - `frame_err` is set to the inverse of the stop bit.
- R6: 11-bit asynchronous receive (mode 2).
  - The received ninth bit goes to `rx_bit8`; the stop bit is not stored there.
  - `frame_err` is 1 exactly when the stop bit is 0.
- R7: Each asynchronous bit takes the majority of three samples near mid-bit. A one-clock pulse of the opposite level in the middle of a bit does not change the received value.
- R8: A low pulse on an idle `rxd_in` that is shorter than half a bit does not set `rx_done` and leaves `rx_data` unchanged.
- R9: Done flags.
  - `tx_done` (flag bit 0) and `rx_done` (flag bit 1) are set when their frame ends.
  - A flag is cleared only when `flag_we` is 1 and its bit in `flag_wdata` is 0. Writing a 1 leaves the flag unchanged.
- R10: A pulse on `tx_start` while `tx_busy` is 1 has no effect. The frame in progress finishes with its original data and ninth bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| mode | input | 2 | Selects the mode: 0 = shift, 1 = 10-bit, 2 = 11-bit; the value 3 acts as 1 |
| slow_rate | input | 1 | 11-bit mode rate: 0 = one bit per 16 clocks, 1 = one bit per 32 clocks |
| baud_sel | input | 1 | 10-bit mode tick source: 0 = timer overflow, 1 = rate generator |
| tmr_ovf_tick | input | 1 | Timer overflow pulse, one clock wide |
| gen_tick | input | 1 | Rate generator pulse, one clock wide |
| tx_start | input | 1 | Starts a transmit frame |
| tx_data | input | 8 | Byte to transmit |
| tx_bit9 | input | 1 | Ninth transmit bit |
| rx_start | input | 1 | Starts a shift-mode receive |
| flag_we | input | 1 | Write strobe for the flags |
| flag_wdata | input | 2 | Flag write data: bit 0 = tx_done, bit 1 = rx_done; a 0 clears the flag |
| rxd_in | input | 1 | Receive data line |
| txd | output | 1 | Transmit line, or the shift clock in mode 0 |
| rxd_out | output | 1 | Shift-mode transmit data |
| rxd_oe | output | 1 | Drive enable for `rxd_out` |
| tx_busy | output | 1 | A transmit frame is in progress |
| tx_done | output | 1 | Transmit done flag |
| rx_done | output | 1 | Receive done flag |
| rx_data | output | 8 | Last byte received |
| rx_bit8 | output | 1 | Received ninth bit (mode 2) or stop bit (mode 1) |
| frame_err | output | 1 | The last asynchronous stop bit was 0 |

## Verification
The bench checks where the ninth bit and the stop bit end up in each asynchronous mode. A design that mixed up the two storage rules would show the stop bit in `rx_bit8` in mode 2, or report no framing error when a zero stop bit arrives. It also checks that a shift-mode receive leaves the asynchronous status untouched.

Bit lengths are measured for each tick source and for both mode-2 rates. A design that used the wrong source would drift off the mid-bit sample points within a few bits.

Directed cases cover:
- one-clock glitches in the middle of a bit, which a single-sample receiver would accept;
- a short low pulse on an idle line, which a receiver without mid-bit start validation would turn into a frame;
- a `tx_start` during a frame, which a design that restarts would answer by corrupting the byte on the wire;
- flag writes of 1 versus 0.

// File: rtl/mser_pkg.sv
package mser_pkg;
    localparam int DATA_W = 8;
    localparam int OSR    = 16;
    localparam int OSR_W  = $clog2(OSR);
    localparam int IDX_W  = $clog2(DATA_W);
    localparam int SMP_A  = OSR / 2 - 1;
    localparam int SMP_B  = OSR / 2;
    localparam int SMP_C  = OSR / 2 + 1;

    typedef enum logic [1:0] {
        MODE_SYNC = 2'd0,
        MODE_A10  = 2'd1,
        MODE_A11  = 2'd2
    } ser_mode_e;

    typedef enum logic [2:0] {
        TX_IDLE, TX_START, TX_DATA, TX_NINTH, TX_STOP
    } tx_state_e;

    typedef enum logic [2:0] {
        RX_IDLE, RX_START, RX_DATA, RX_NINTH, RX_STOP
    } rx_state_e;
endpackage

// File: rtl/mser_tick.sv
module mser_tick
    import mser_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  ser_mode_e mode,
    input  logic      slow_rate,
    input  logic      baud_sel,
    input  logic      tmr_tick,
    input  logic      gen_tick,
    output logic      os_tick
);
    logic phase_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) phase_q <= 1'b0;
        else        phase_q <= ~phase_q;
    end

    always_comb begin
        unique case (mode)
            MODE_SYNC: os_tick = 1'b1;
            MODE_A11:  os_tick = slow_rate ? phase_q : 1'b1;
            MODE_A10:  os_tick = baud_sel ? gen_tick : tmr_tick;
            default:   os_tick = 1'b0;
        endcase
    end

    AST_SYNC_EVERY_CLK: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_SYNC) |-> os_tick) else $error("sync tick missing"); // R1
endmodule

// File: rtl/mser_tx.sv
module mser_tx
    import mser_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              os_tick,
    input  ser_mode_e         mode,
    input  logic              start,
    input  logic [DATA_W-1:0] data,
    input  logic              bit9,
    output logic              busy,
    output logic              done_pulse,
    output logic              line,
    output logic              sclk,
    output logic              sdo,
    output logic              sdo_en
);
    tx_state_e         state;
    ser_mode_e         fmode;
    logic [OSR_W-1:0]  cnt;
    logic [IDX_W-1:0]  idx;
    logic [DATA_W-1:0] sh;
    logic              b9_q;
    logic              bit_end;

    assign bit_end = os_tick && (cnt == OSR_W'(OSR - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state      <= TX_IDLE;
            fmode      <= MODE_SYNC;
            cnt        <= '0;
            idx        <= '0;
            sh         <= '0;
            b9_q       <= 1'b0;
            done_pulse <= 1'b0;
        end else begin
            done_pulse <= 1'b0;
            if (state == TX_IDLE) begin
                if (start) begin
                    sh    <= data;
                    b9_q  <= bit9;
                    fmode <= mode;
                    cnt   <= '0;
                    idx   <= '0;
                    state <= (mode == MODE_SYNC) ? TX_DATA : TX_START;
                end
            end else if (os_tick) begin
                cnt <= cnt + 1'b1;
                if (bit_end) begin
                    unique case (state)
                        TX_START: state <= TX_DATA;
                        TX_DATA: begin
                            sh  <= sh >> 1;
                            idx <= idx + 1'b1;
                            if (idx == IDX_W'(DATA_W - 1)) begin
                                if (fmode == MODE_SYNC) begin
                                    state      <= TX_IDLE;
                                    done_pulse <= 1'b1;
                                end else if (fmode == MODE_A11) begin
                                    state <= TX_NINTH;
                                end else begin
                                    state <= TX_STOP;
                                end
                            end
                        end
                        TX_NINTH: state <= TX_STOP;
                        TX_STOP: begin
                            state      <= TX_IDLE;
                            done_pulse <= 1'b1;
                        end
                        default: state <= TX_IDLE;
                    endcase
                end
            end
        end
    end

    always_comb begin
        busy   = (state != TX_IDLE);
        sdo_en = (state == TX_DATA) && (fmode == MODE_SYNC);
        sdo    = sdo_en ? sh[0] : 1'b1;
        sclk   = sdo_en ? cnt[OSR_W-1] : 1'b1;
        unique case (state)
            TX_START: line = 1'b0;
            TX_DATA:  line = (fmode == MODE_SYNC) ? 1'b1 : sh[0];
            TX_NINTH: line = b9_q;
            default:  line = 1'b1;
        endcase
    end

    AST_TX_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (state != TX_IDLE && start) |=> ($stable(b9_q) && $stable(fmode))) else $error("restart while busy"); // R10
    AST_TX_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_pulse |-> (state == TX_IDLE)) else $error("done while busy"); // R9
endmodule

// File: rtl/mser_rx.sv
module mser_rx
    import mser_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              os_tick,
    input  ser_mode_e         mode,
    input  logic              go,
    input  logic              rxd,
    output logic              busy,
    output logic              sclk,
    output logic              done_pulse,
    output logic [DATA_W-1:0] data_q,
    output logic              bit8_q,
    output logic              ferr_q
);
    rx_state_e         state;
    ser_mode_e         fmode;
    logic [OSR_W-1:0]  cnt;
    logic [IDX_W-1:0]  idx;
    logic [DATA_W-1:0] sh;
    logic              s_a, s_b, ninth_q, maj;

    assign maj = (s_a & s_b) | (s_a & rxd) | (s_b & rxd);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state      <= RX_IDLE;
            fmode      <= MODE_SYNC;
            cnt        <= '0;
            idx        <= '0;
            sh         <= '0;
            s_a        <= 1'b1;
            s_b        <= 1'b1;
            ninth_q    <= 1'b0;
            data_q     <= '0;
            bit8_q     <= 1'b0;
            ferr_q     <= 1'b0;
            done_pulse <= 1'b0;
        end else begin
            done_pulse <= 1'b0;
            if (state == RX_IDLE) begin
                cnt <= '0;
                idx <= '0;
                if (mode == MODE_SYNC) begin
                    if (go) begin
                        fmode <= MODE_SYNC;
                        state <= RX_DATA;
                    end
                end else if (os_tick && !rxd) begin
                    fmode <= mode;
                    state <= RX_START;
                end
            end else if (os_tick) begin
                cnt <= cnt + 1'b1;
                if (cnt == OSR_W'(SMP_A)) s_a <= rxd;
                if (cnt == OSR_W'(SMP_B)) s_b <= rxd;
                if (cnt == OSR_W'(SMP_C)) begin
                    unique case (state)
                        RX_START: if (maj) state <= RX_IDLE;
                        RX_DATA:  sh <= {maj, sh[DATA_W-1:1]};
                        RX_NINTH: ninth_q <= maj;
                        RX_STOP: begin
                            data_q     <= sh;
                            bit8_q     <= (fmode == MODE_A11) ? ninth_q : maj;
                            ferr_q     <= ~maj;
                            done_pulse <= 1'b1;
                            state      <= RX_IDLE;
                        end
                        default: state <= RX_IDLE;
                    endcase
                end
                if (cnt == OSR_W'(OSR - 1)) begin
                    unique case (state)
                        RX_START: state <= RX_DATA;
                        RX_DATA: begin
                            idx <= idx + 1'b1;
                            if (idx == IDX_W'(DATA_W - 1)) begin
                                if (fmode == MODE_SYNC) begin
                                    data_q     <= sh;
                                    done_pulse <= 1'b1;
                                    state      <= RX_IDLE;
                                end else if (fmode == MODE_A11) begin
                                    state <= RX_NINTH;
                                end else begin
                                    state <= RX_STOP;
                                end
                            end
                        end
                        RX_NINTH: state <= RX_STOP;
                        default:  state <= state;
                    endcase
                end
            end
        end
    end

    always_comb begin
        busy = (state != RX_IDLE);
        sclk = (state == RX_DATA && fmode == MODE_SYNC) ? cnt[OSR_W-1] : 1'b1;
    end

    AST_RX_SYNC_KEEPS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
        (done_pulse && fmode == MODE_SYNC) |-> ($stable(bit8_q) && $stable(ferr_q))) else $error("sync rx touched status"); // R2
    AST_RX_ASYNC_DONE_FROM_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        (done_pulse && fmode != MODE_SYNC) |-> ($past(state) == RX_STOP)) else $error("async done not from stop"); // R5
    AST_RX_FALSE_START: assert property (@(posedge clk) disable iff (!rst_n)
        (state == RX_START && os_tick && cnt == OSR_W'(SMP_C) && maj) |=> (state == RX_IDLE && !done_pulse)) else $error("false start accepted"); // R8
endmodule

// File: rtl/mser_core.sv
module mser_core
    import mser_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        mode,
    input  logic              slow_rate,
    input  logic              baud_sel,
    input  logic              tmr_ovf_tick,
    input  logic              gen_tick,
    input  logic              tx_start,
    input  logic [DATA_W-1:0] tx_data,
    input  logic              tx_bit9,
    input  logic              rx_start,
    input  logic              flag_we,
    input  logic [1:0]        flag_wdata,
    input  logic              rxd_in,
    output logic              txd,
    output logic              rxd_out,
    output logic              rxd_oe,
    output logic              tx_busy,
    output logic              tx_done,
    output logic              rx_done,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_bit8,
    output logic              frame_err
);
    ser_mode_e md;
    logic      os_tick, rxd_m, rxd_s;
    logic      tx_line, tx_sclk, tx_fin;
    logic      rx_busy, rx_sclk, rx_fin;

    always_comb begin
        case (mode)
            2'd0:    md = MODE_SYNC;
            2'd2:    md = MODE_A11;
            default: md = MODE_A10;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rxd_m <= 1'b1;
            rxd_s <= 1'b1;
        end else begin
            rxd_m <= rxd_in;
            rxd_s <= rxd_m;
        end
    end

    mser_tick u_tick (
        .clk(clk), .rst_n(rst_n), .mode(md), .slow_rate(slow_rate),
        .baud_sel(baud_sel), .tmr_tick(tmr_ovf_tick), .gen_tick(gen_tick),
        .os_tick(os_tick)
    );

    mser_tx u_tx (
        .clk(clk), .rst_n(rst_n), .os_tick(os_tick), .mode(md),
        .start(tx_start), .data(tx_data), .bit9(tx_bit9),
        .busy(tx_busy), .done_pulse(tx_fin), .line(tx_line), .sclk(tx_sclk),
        .sdo(rxd_out), .sdo_en(rxd_oe)
    );

    mser_rx u_rx (
        .clk(clk), .rst_n(rst_n), .os_tick(os_tick), .mode(md),
        .go(rx_start), .rxd(rxd_s), .busy(rx_busy), .sclk(rx_sclk),
        .done_pulse(rx_fin), .data_q(rx_data), .bit8_q(rx_bit8), .ferr_q(frame_err)
    );

    assign txd = tx_line & tx_sclk & rx_sclk;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_done <= 1'b0;
            rx_done <= 1'b0;
        end else begin
            if (tx_fin)                        tx_done <= 1'b1;
            else if (flag_we && !flag_wdata[0]) tx_done <= 1'b0;
            if (rx_fin)                        rx_done <= 1'b1;
            else if (flag_we && !flag_wdata[1]) rx_done <= 1'b0;
        end
    end

    AST_TXD_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_busy && !rx_busy) |-> txd) else $error("txd low while idle"); // R1
    AST_OE_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        rxd_oe |-> tx_busy) else $error("oe without frame"); // R1
    AST_TX_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_done && !(flag_we && !flag_wdata[0])) |=> tx_done) else $error("tx flag lost"); // R9
    AST_RX_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_done && !(flag_we && !flag_wdata[1])) |=> rx_done) else $error("rx flag lost"); // R9
endmodule

// File: tb/mser_core_tb.sv
module mser_core_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] mode = 2'd0;
    logic       slow_rate = 1'b0, baud_sel = 1'b0;
    logic       tmr_ovf_tick = 1'b0, gen_tick = 1'b0;
    logic       tx_start = 1'b0, tx_bit9 = 1'b0, rx_start = 1'b0;
    logic [7:0] tx_data = 8'h00;
    logic       flag_we = 1'b0;
    logic [1:0] flag_wdata = 2'b00;
    logic       rxd_in = 1'b1;
    logic       txd, rxd_out, rxd_oe, tx_busy, tx_done, rx_done, rx_bit8, frame_err;
    logic [7:0] rx_data;

    int total = 0;
    int bad   = 0;
    logic [7:0] exp_data = 8'h00;
    logic       exp_b8 = 1'b0, exp_fe = 1'b0;

    always #10 clk = ~clk;

    mser_core u_dut (
        .clk(clk), .rst_n(rst_n), .mode(mode), .slow_rate(slow_rate),
        .baud_sel(baud_sel), .tmr_ovf_tick(tmr_ovf_tick), .gen_tick(gen_tick),
        .tx_start(tx_start), .tx_data(tx_data), .tx_bit9(tx_bit9),
        .rx_start(rx_start), .flag_we(flag_we), .flag_wdata(flag_wdata),
        .rxd_in(rxd_in), .txd(txd), .rxd_out(rxd_out), .rxd_oe(rxd_oe),
        .tx_busy(tx_busy), .tx_done(tx_done), .rx_done(rx_done),
        .rx_data(rx_data), .rx_bit8(rx_bit8), .frame_err(frame_err)
    );

    // timer overflow every 3 clocks, rate generator every 4 clocks
    initial begin
        int c3 = 0;
        int c4 = 0;
        forever begin
            @(negedge clk);
            c3 = (c3 == 2) ? 0 : c3 + 1;
            c4 = (c4 == 3) ? 0 : c4 + 1;
            tmr_ovf_tick = (c3 == 0);
            gen_tick     = (c4 == 0);
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int period(input logic [1:0] md, input logic half, input logic sel);
        if (md == 2'd0) return 1;
        if (md == 2'd2) return half ? 2 : 1;
        return sel ? 4 : 3;
    endfunction

    function automatic int frame_len(input logic [1:0] md);
        return (md == 2'd2) ? 11 : 10;
    endfunction

    function automatic logic frame_bit(input logic [1:0] md, input logic [7:0] d,
                                       input logic b9, input logic stp, input int i);
        if (i == 0) return 1'b0;
        if (i <= 8) return d[i-1];
        if (i == 9) return (md == 2'd2) ? b9 : stp;
        return stp;
    endfunction

    task automatic clear_flags(input logic [1:0] w);
        @(negedge clk); flag_we = 1'b1; flag_wdata = w;
        @(negedge clk); flag_we = 1'b0;
    endtask

    task automatic setup(input logic [1:0] md, input logic half, input logic sel);
        @(negedge clk); mode = md; slow_rate = half; baud_sel = sel;
        repeat (4) @(negedge clk);
    endtask

    // shift-mode transmit: R1
    task automatic tx_sync(input logic [7:0] d);
        setup(2'd0, 1'b0, 1'b0);
        tx_data = d; tx_start = 1'b1;
        @(negedge clk); tx_start = 1'b0;
        for (int i = 0; i < 8; i++) begin
            repeat (4) @(negedge clk);
            check("R1 sclk low", txd, 1'b0);
            check("R1 data bit", rxd_out, d[i]);
            check("R1 oe", rxd_oe, 1'b1);
            repeat (8) @(negedge clk);
            check("R1 sclk high", txd, 1'b1);
            repeat (4) @(negedge clk);
        end
        repeat (2) @(negedge clk);
        check("R1 idle oe", rxd_oe, 1'b0);
        check("R1 idle txd", txd, 1'b1);
        check("R9 tx done sync", tx_done, 1'b1);
        clear_flags(2'b00);
    endtask

    // asynchronous transmit: R3, R4, R10
    task automatic tx_async(input logic [1:0] md, input logic [7:0] d, input logic b9,
                            input logic half, input logic sel, input bit bump);
        int p;
        int n;
        p = period(md, half, sel);
        n = frame_len(md);
        setup(md, half, sel);
        tx_data = d; tx_bit9 = b9; tx_start = 1'b1;
        @(negedge clk); tx_start = 1'b0;
        repeat (8 * p) @(negedge clk);
        for (int i = 0; i < n; i++) begin
            check(md == 2'd2 ? "R4 frame bit" : "R3 frame bit", txd, frame_bit(md, d, b9, 1'b1, i));
            check("R10 busy", tx_busy, 1'b1);
            if (bump && i == 3) begin
                tx_start = 1'b1; tx_data = ~d; tx_bit9 = ~b9;
                @(negedge clk); tx_start = 1'b0;
                repeat (16 * p - 1) @(negedge clk);
            end else begin
                repeat (16 * p) @(negedge clk);
            end
        end
        check("R9 tx done", tx_done, 1'b1);
        check("R3 tx idle", tx_busy, 1'b0);
        clear_flags(2'b00);
    endtask

    // asynchronous receive: R5, R6, R7
    task automatic rx_async(input logic [1:0] md, input logic [7:0] d, input logic b9,
                            input logic stp, input logic half, input logic sel, input bit glitch);
        int p;
        int n;
        logic v;
        p = period(md, half, sel);
        n = frame_len(md);
        setup(md, half, sel);
        for (int i = 0; i < n; i++) begin
            v = frame_bit(md, d, b9, stp, i);
            rxd_in = v;
            if (glitch && (i == 2 || i == 5)) begin
                repeat (8 * p) @(negedge clk);
                rxd_in = ~v;
                @(negedge clk);
                rxd_in = v;
                repeat (8 * p - 1) @(negedge clk);
            end else begin
                repeat (16 * p) @(negedge clk);
            end
        end
        rxd_in = 1'b1;
        repeat (4 * p) @(negedge clk);
        exp_data = d;
        exp_b8   = (md == 2'd2) ? b9 : stp;
        exp_fe   = ~stp;
        check(glitch ? "R7 data" : (md == 2'd2 ? "R6 data" : "R5 data"), rx_data, exp_data);
        check(md == 2'd2 ? "R6 bit8" : "R5 bit8", rx_bit8, exp_b8);
        check(md == 2'd2 ? "R6 ferr" : "R5 ferr", frame_err, exp_fe);
        check("R9 rx done", rx_done, 1'b1);
        repeat (24 * p) @(negedge clk);
        clear_flags(2'b00);
    endtask

    // shift-mode receive: R2
    task automatic rx_sync(input logic [7:0] d);
        setup(2'd0, 1'b0, 1'b0);
        rxd_in = d[0]; rx_start = 1'b1;
        @(negedge clk); rx_start = 1'b0;
        for (int i = 0; i < 8; i++) begin
            rxd_in = d[i];
            repeat (4) @(negedge clk);
            check("R2 sclk low", txd, 1'b0);
            repeat (8) @(negedge clk);
            check("R2 sclk high", txd, 1'b1);
            repeat (4) @(negedge clk);
        end
        rxd_in = 1'b1;
        repeat (3) @(negedge clk);
        exp_data = d;
        check("R2 data", rx_data, exp_data);
        check("R2 bit8 kept", rx_bit8, exp_b8);
        check("R2 ferr kept", frame_err, exp_fe);
        check("R2 done", rx_done, 1'b1);
        clear_flags(2'b00);
    endtask

    initial begin
        logic [31:0] seed_val;
        seed_val = $urandom(32'd20240611);
        repeat (5) @(negedge clk);
        check("R1 reset txd", txd, 1'b1);
        check("R1 reset oe", rxd_oe, 1'b0);
        check("R9 reset flags", {tx_done, rx_done}, 2'b00);
        check("R5 reset data", rx_data, 8'h00);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        tx_sync(8'hA5);
        tx_sync(8'h01);
        tx_async(2'd1, 8'h3C, 1'b0, 1'b0, 1'b0, 1'b0);   // R3 timer tick
        tx_async(2'd1, 8'hC3, 1'b0, 1'b0, 1'b1, 1'b0);   // R3 generator tick
        tx_async(2'd2, 8'h96, 1'b1, 1'b0, 1'b0, 1'b0);   // R4 fast
        tx_async(2'd2, 8'h69, 1'b0, 1'b1, 1'b0, 1'b0);   // R4 slow
        tx_async(2'd2, 8'h5A, 1'b1, 1'b0, 1'b0, 1'b1);   // R10 start while busy

        rx_async(2'd1, 8'h81, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0); // R5
        rx_async(2'd1, 8'h7E, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0); // R5 framing error
        rx_async(2'd2, 8'h42, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0); // R6
        rx_async(2'd2, 8'hBD, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0); // R6 stop not stored
        rx_async(2'd2, 8'hE7, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0); // R6 framing error
        rx_async(2'd2, 8'hC9, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1); // R7 glitches
        rx_sync(8'h5B);                                       // R2

        // R8: short low pulse on idle line
        setup(2'd2, 1'b0, 1'b0);
        rxd_in = 1'b0;
        repeat (3) @(negedge clk);
        rxd_in = 1'b1;
        repeat (60) @(negedge clk);
        check("R8 no done", rx_done, 1'b0);
        check("R8 data kept", rx_data, exp_data);

        // R9: sticky flags and write-zero clear
        tx_data = 8'h11; tx_start = 1'b1;
        @(negedge clk); tx_start = 1'b0;
        repeat (200) @(negedge clk);
        check("R9 held", tx_done, 1'b1);
        clear_flags(2'b11);
        check("R9 write one keeps", tx_done, 1'b1);
        rx_async(2'd2, 8'h24, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
        tx_data = 8'h22; tx_start = 1'b1;
        @(negedge clk); tx_start = 1'b0;
        repeat (200) @(negedge clk);
        rxd_in = 1'b1;
        setup(2'd2, 1'b0, 1'b0);
        rx_start = 1'b0;
        // rx flag set by a fresh frame, then clear only tx
        for (int i = 0; i < 11; i++) begin
            rxd_in = frame_bit(2'd2, 8'h33, 1'b0, 1'b1, i);
            repeat (16) @(negedge clk);
        end
        rxd_in = 1'b1;
        repeat (8) @(negedge clk);
        clear_flags(2'b10);
        check("R9 tx cleared", tx_done, 1'b0);
        check("R9 rx kept", rx_done, 1'b1);
        clear_flags(2'b00);
        check("R9 rx cleared", rx_done, 1'b0);

        // constrained random mix
        for (int k = 0; k < 12; k++) begin
            logic [1:0] md;
            logic [7:0] d;
            logic b9, half, sel, stp;
            md   = ($urandom() & 1) ? 2'd2 : 2'd1;
            d    = 8'($urandom());
            b9   = 1'($urandom());
            half = 1'($urandom());
            sel  = 1'($urandom());
            stp  = (($urandom() % 4) != 0);
            tx_async(md, d, b9, half, sel, 1'b0);
            rx_async(md, d, b9, stp, half, sel, 1'b0);
            if (k % 4 == 0) begin
                rx_sync(~d);
                tx_sync(d);
            end
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule